// File: doc/BRIEF.md
# Write-Once Timer Prescaler and Interrupt Mask

This block holds the interrupt-enable bits and the clock-divide selection for a 16-bit free-running timer. It is a single 8-bit register on a simple register bus. The 2-bit divide selection sets how often the counter advances: every clock, every 4, every 8 or every 16 clocks. When the counter wraps from all ones to zero, an overflow flag is set. A write-one-to-clear strobe clears it.

Four interrupt sources are carried. These are the timer overflow and three external flags: a periodic-tick flag, an accumulator-overflow flag and an accumulator-edge flag. Each source raises its request line only when its flag and its enable bit are both 1.

In normal operation the divide selection is protected. It accepts one write, and only during a short window after reset. A mode input allows unrestricted rewrites. A new selection never cuts a counter tick short, because it is picked up at the next terminal count of the divider.

Top module: `tmr_presc_mask`

## Requirements
- R1: Register layout: bit 7 enables overflow, bit 6 the periodic-tick flag, bit 5 the accumulator-overflow flag, bit 4 the accumulator-edge flag, and bits 1:0 are the divide selection. `reg_rdata` shows the register while `reg_sel` is 1 and reads 0 otherwise. A write happens on a clock edge where `reg_sel` and `reg_wr` are both 1.
- R2: Bits 3:2 always read 0, whatever is written to them.
- R3: After reset the register, the counter and the overflow flag are all 0.
- R4: With `special_mode` low, the divide selection takes only the first write, and only if that write lands on one of clock edges 1 to 64 after reset release. Any second write or later write leaves it unchanged.
- R5: Selection 00, 01, 10 and 11 make the counter advance by one every 1, 4, 8 and 16 clocks.
- R6: A new selection is applied only at the next terminal count of the ratio in force. The first tick after a change therefore keeps the old spacing.
- R7: The overflow flag sets on the tick that takes the counter from 0xFFFF to 0x0000. `ovf_clr` clears it on the next edge. If both happen on the same edge, the set wins.
- R8: `irq_vec` is {overflow, tick, acc-overflow, acc-edge}, and each bit is its flag AND its enable. `ext_flags` is {tick, acc-overflow, acc-edge}. `irq_any` is the OR of `irq_vec`.
- R9: With `special_mode` high, every write updates the divide selection, and these writes do not use up the single normal-mode write.
- R10: The four enable bits take every write, in either mode, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Address match for the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| special_mode | input | 1 | 1 = divide selection unrestricted |
| ext_flags | input | 3 | {tick, acc-overflow, acc-edge} flags |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_value | output | 16 | Free-running counter |
| ovf_flag | output | 1 | Overflow flag |
| irq_vec | output | 4 | Per-source interrupt requests |
| irq_any | output | 1 | OR of all requests |

## Verification
Two pairs of functions can fall on the same edge. The first pair is the counter wrap setting the overflow flag and the clear strobe removing it. The bench waits until the counter shows 0xFFFF at divide-by-1, raises `ovf_clr` for exactly that edge, and expects the flag to stay set. The second pair is a divider terminal count and a write of a new selection. The bench detects a counter step, writes a new ratio on the following edge, and times the next two steps: the first must keep the old spacing and the second must use the new one. A behavioural model runs alongside and is compared on every clock.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int REG_W   = 8;
  localparam int EN_HI   = 7;
  localparam int EN_LO   = 4;
  localparam int NUM_SRC = EN_HI - EN_LO + 1;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV8  = 2'b10,
    PS_DIV16 = 2'b11
  } presc_e;

  // last divider count value for each ratio
  function automatic logic [3:0] term_of(presc_e s);
    case (s)
      PS_DIV1:  term_of = 4'd0;
      PS_DIV4:  term_of = 4'd3;
      PS_DIV8:  term_of = 4'd7;
      default:  term_of = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/tpm_mask_reg.sv
module tpm_mask_reg
  import tpm_pkg::*;
#(
  parameter int WIN_CYC = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic [REG_W-1:0]    wdata,
  input  logic                special_mode,
  output logic [NUM_SRC-1:0]  en_q,
  output presc_e              pr_q
);
  localparam int WCW = $clog2(WIN_CYC + 1);

  logic [WCW-1:0]     win_q, win_d;
  logic               done_q, done_d;
  logic [NUM_SRC-1:0] en_d;
  presc_e             pr_d;
  logic               win_live, win_open, pr_take;

  always_comb begin
    win_live = (win_q < WCW'(WIN_CYC));
    win_open = win_live && !done_q;
    pr_take  = wr_hit && (special_mode || win_open);
    en_d     = wr_hit ? wdata[EN_HI:EN_LO] : en_q;
    pr_d     = pr_take ? presc_e'(wdata[1:0]) : pr_q;
    done_d   = done_q | (wr_hit && !special_mode && win_open);
    win_d    = win_live ? win_q + WCW'(1) : win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      done_q <= 1'b0;
      en_q   <= '0;
      pr_q   <= PS_DIV1;
    end else begin
      win_q  <= win_d;
      done_q <= done_d;
      en_q   <= en_d;
      pr_q   <= pr_d;
    end
  end

  // R4
  sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && !win_open) |=> $stable(pr_q));
  // R4
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !special_mode && win_open) |=> done_q);
  // R10
  en_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (en_q == $past(wdata[EN_HI:EN_LO])));
endmodule

// File: rtl/tpm_prescaler.sv
module tpm_prescaler
  import tpm_pkg::*;
#(
  parameter int PCW = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  presc_e pr_sel,
  output logic   tick
);
  presc_e         act_q, act_d;
  logic [PCW-1:0] pc_q, pc_d;
  logic           tc;

  always_comb begin
    tc    = (pc_q == PCW'(term_of(act_q)));
    pc_d  = tc ? '0 : pc_q + PCW'(1);
    act_d = tc ? pr_sel : act_q;
    tick  = tc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      act_q <= PS_DIV1;
    end else begin
      pc_q  <= pc_d;
      act_q <= act_d;
    end
  end

  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(act_q));
  // R5
  div1_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == PS_DIV1) |-> tick);
endmodule

// File: rtl/tpm_freerun.sv
module tpm_freerun #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ovf_clr,
  output logic [CW-1:0] cnt_q,
  output logic          ovf_q
);
  logic [CW-1:0] cnt_d;
  logic          ovf_d, wrap;

  always_comb begin
    wrap  = tick && (cnt_q == '1);
    cnt_d = tick ? cnt_q + CW'(1) : cnt_q;
    if (wrap)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // R7
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ovf_q && cnt_q == '0));
  // R7
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !wrap) |=> !ovf_q);
  // R5
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_presc_mask.sv
module tmr_presc_mask
  import tpm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int WIN_CYC = 64,
  parameter int PRE_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               special_mode,
  input  logic [NUM_SRC-2:0] ext_flags,
  input  logic               ovf_clr,
  output logic [CNT_W-1:0]   cnt_value,
  output logic               ovf_flag,
  output logic [NUM_SRC-1:0] irq_vec,
  output logic               irq_any
);
  logic [NUM_SRC-1:0] en;
  presc_e             pr;
  logic               tick, wr_hit;

  assign wr_hit = reg_sel && reg_wr;

  tpm_mask_reg #(.WIN_CYC(WIN_CYC)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(reg_wdata),
    .special_mode(special_mode), .en_q(en), .pr_q(pr)
  );

  tpm_prescaler #(.PCW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .pr_sel(pr), .tick(tick)
  );

  tpm_freerun #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ovf_clr(ovf_clr),
    .cnt_q(cnt_value), .ovf_q(ovf_flag)
  );

  always_comb begin
    irq_vec   = {ovf_flag, ext_flags} & en;
    irq_any   = |irq_vec;
    reg_rdata = reg_sel ? {en, 2'b00, pr} : '0;
  end

  // R8
  ovf_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en[NUM_SRC-1] |-> !irq_vec[NUM_SRC-1]);
  // R2
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3:2] == 2'b00);
endmodule

// File: tb/test_tmr_presc_mask.sv
`timescale 1ns/1ps
module test_tmr_presc_mask;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b1, reg_wr = 1'b0, special_mode = 1'b0, ovf_clr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [2:0] ext_flags = 3'b000;
  logic [7:0] reg_rdata;
  logic [15:0] cnt_value;
  logic       ovf_flag, irq_any;
  logic [3:0] irq_vec;

  int checks = 0, errors = 0;
  bit run = 0, done = 0;

  always #10 clk = ~clk;

  tmr_presc_mask i_tmr_presc_mask (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .special_mode(special_mode),
    .ext_flags(ext_flags), .ovf_clr(ovf_clr), .cnt_value(cnt_value),
    .ovf_flag(ovf_flag), .irq_vec(irq_vec), .irq_any(irq_any)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_en, m_pr, m_act, m_pc, m_cnt, m_ovf, m_win, m_used;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pr = 0; m_act = 0; m_pc = 0; m_cnt = 0; m_ovf = 0; m_win = 0; m_used = 0;
    end else begin
      int div, o_pr;
      bit t, w, ok;
      o_pr = m_pr;
      div  = (m_act == 0) ? 1 : (m_act == 1) ? 4 : (m_act == 2) ? 8 : 16;
      t    = (m_pc == div - 1);
      w    = reg_sel && reg_wr;
      ok   = !special_mode && m_win < 64 && m_used == 0;
      if (w) m_en = reg_wdata[7:4];
      if (w && (special_mode || ok)) m_pr = reg_wdata[1:0];
      if (w && ok) m_used = 1;
      if (m_win < 64) m_win++;
      if (t) begin
        if (m_cnt == 65535) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
        m_cnt = (m_cnt + 1) % 65536;
        m_pc = 0; m_act = o_pr;
      end else begin
        if (ovf_clr) m_ovf = 0;
        m_pc++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      int iv;
      #2;
      iv = ({m_ovf[0], ext_flags}) & m_en[3:0];
      chk("R5 cnt_value", cnt_value, m_cnt);
      chk("R7 ovf_flag", ovf_flag, m_ovf);
      chk("R8 irq_vec", irq_vec, iv);
      chk("R8 irq_any", irq_any, iv != 0);
      chk("R1 reg_rdata", reg_rdata, reg_sel ? ((m_en << 4) | m_pr) : 0);
    end
  end

  task automatic do_reset();
    run = 0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; run = 1;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(output int v);
    @(negedge clk); #3; v = reg_rdata;
  endtask

  task automatic rate(int cycles, output int d);
    int a;
    @(negedge clk); #3; a = cnt_value;
    repeat (cycles) @(negedge clk);
    #3; d = (cnt_value - a + 65536) % 65536;
  endtask

  task automatic wait_cnt(int v);
    do begin @(negedge clk); #3; end while (cnt_value != v);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, g1, g2;
    #5;
    // R3 reset state
    do_reset();
    #3;
    chk("R3 rdata after reset", reg_rdata, 0);
    chk("R3 counter after reset", cnt_value, 0);
    chk("R3 flag after reset", ovf_flag, 0);
    // R1 R2: first write inside window
    wr(8'hFF); rd(v);
    chk("R2 gap bits read 0", v, 8'hF3);
    reg_sel = 1'b0; #1;
    chk("R1 unselected read", reg_rdata, 0);
    reg_sel = 1'b1;
    // R4 second write ignored, R10 enables follow
    wr(8'h01); rd(v);
    chk("R4 second write ignored / R10 enables", v, 8'h03);
    repeat (20) @(negedge clk);
    rate(32, v); chk("R5 divide by 16", v, 2);

    // R4 late write ignored
    do_reset();
    repeat (70) @(negedge clk);
    wr(8'h02); rd(v);
    chk("R4 late write ignored", v, 8'h00);
    wr(8'hC0); rd(v);
    chk("R10 late enable write", v, 8'hC0);
    rate(10, v); chk("R5 divide by 1", v, 10);
    ext_flags = 3'b101;
    @(negedge clk); #3;
    chk("R8 flag masking", irq_vec, 4'b0100);
    wait_cnt(16'hFFFF);
    @(negedge clk); #3;
    chk("R7 flag set on wrap", ovf_flag, 1);
    chk("R8 overflow request", irq_vec[3], 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; #3;
    chk("R7 clear strobe", ovf_flag, 0);
    chk("R8 request drops", irq_vec[3], 0);
    wait_cnt(16'hFFFF);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; #3;
    chk("R7 set wins over clear", ovf_flag, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;

    // R9 special mode rewrites
    special_mode = 1'b1;
    wr(8'h02); rd(v);
    chk("R9 special rewrite", v, 8'h02);
    repeat (20) @(negedge clk);
    rate(32, v); chk("R5 divide by 8", v, 4);
    wr(8'h01);
    repeat (40) @(negedge clk);
    rate(32, v); chk("R5 divide by 4", v, 8);
    // R6 change right after a tick
    #3; v = cnt_value;
    do begin @(negedge clk); #3; end while (cnt_value == v);
    reg_wr = 1'b1; reg_wdata = 8'h03;
    v = cnt_value; g1 = 0;
    do begin @(negedge clk); reg_wr = 1'b0; #3; g1++; end while (cnt_value == v);
    v = cnt_value; g2 = 0;
    do begin @(negedge clk); #3; g2++; end while (cnt_value == v && g2 < 40);
    chk("R6 old spacing kept", g1, 4);
    chk("R6 new spacing after tc", g2, 16);
    rd(v);
    chk("R9 special write landed", v, 8'h03);

    run = 0; done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule